// File: doc/BRIEF.md
# Software Interrupt Pending Controller

This block keeps a 17-bit register of software interrupt pending flags and a 4-bit processor priority level. From those two it builds a registered 17-bit vector of posted interrupt requests, one per flag, that the core's trap logic reads.

Software changes the flags in three ways. A direct write replaces the whole register. A set write ORs its data into the register. A clear write removes the bits that are one in its data. The set and clear paths each have a valid/ready handshake. When both present in the same cycle, a two-state arbiter accepts one of them and holds the other off. The arbiter's states are `ARB_FAVOR_SET` (the reset state) and `ARB_FAVOR_CLR`. It moves from `ARB_FAVOR_SET` to `ARB_FAVOR_CLR` when a contested cycle grants the set path, and from `ARB_FAVOR_CLR` back to `ARB_FAVOR_SET` when a contested cycle grants the clear path. An uncontested cycle leaves the state where it is.

The two end bits, 0 and 16, are the timer match flags. They are gated by a fixed level threshold. The inner bits are gated by their own index against the level.

Top module: `swirq_pend_ctrl`

## Requirements
- R1: After reset the flag register, the level register and the request vector are all zero.
- R2: A direct write (`dir_we` high) loads `dir_data` into the flag register at the next clock edge.
- R3: An accepted set write (`set_valid` and `set_ready` both high) makes the register equal to its old value OR `set_data`.
- R4: An accepted clear write (`clr_valid` and `clr_ready` both high) makes the register equal to its old value AND NOT `clr_data`.
- R5: Request bits 0 and 16 are high exactly when the matching flag is set and the level is below 14.
- R6: Each request bit i, for i from 1 to 15, is high exactly when flag i is set and i is strictly greater than the level.
- R7: A level write (`pil_we`) loads `pil_data`. The request vector is re-evaluated at the same clock edge at which the flag register or the level register takes a new value.
- R8: In a cycle with no direct write and both `set_valid` and `clr_valid` high, exactly one ready is high. The set path wins the first such cycle after reset, and the winner alternates on each later contested cycle.
- R9: A direct write takes precedence: while `dir_we` is high, both `set_ready` and `clr_ready` are low, and the set and clear data have no effect on the register.
- R10: With no direct write, a lone valid on either path sees its ready high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_we | input | 1 | Direct write strobe |
| dir_data | input | 17 | Direct write value |
| set_valid | input | 1 | Set write request |
| set_data | input | 17 | Bits to set |
| set_ready | output | 1 | Set write accepted this cycle |
| clr_valid | input | 1 | Clear write request |
| clr_data | input | 17 | Bits to clear |
| clr_ready | output | 1 | Clear write accepted this cycle |
| pil_we | input | 1 | Level write strobe |
| pil_data | input | 4 | New level |
| soft_rd | output | 17 | Flag register read-back |
| pil_rd | output | 4 | Level register read-back |
| int_req | output | 17 | Posted request vector |

## Verification
The ready outputs are combinational. The bench reads them one time step after it drives the inputs, while still ahead of the clock edge. The flag register, the level register and the request vector all change at the edge that samples the write, so each is due exactly one cycle after its stimulus. The bench compares them at the following falling edge against a model that it advances itself.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
    localparam int unsigned SWIRQ_W     = 17;
    localparam int unsigned SWIRQ_LVL_W = 4;
    localparam int unsigned SWIRQ_GATE  = 14;

    typedef enum logic {
        ARB_FAVOR_SET = 1'b0,
        ARB_FAVOR_CLR = 1'b1
    } arb_state_e;
endpackage

// File: rtl/swirq_arb.sv
module swirq_arb
    import swirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_we,
    input  logic set_valid,
    input  logic clr_valid,
    output logic set_ready,
    output logic clr_ready
);
    arb_state_e state_q, state_d;
    logic       contest;

    assign contest = set_valid && clr_valid && !dir_we;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FAVOR_SET: if (contest) state_d = ARB_FAVOR_CLR;
            ARB_FAVOR_CLR: if (contest) state_d = ARB_FAVOR_SET;
            default:       state_d = ARB_FAVOR_SET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_FAVOR_SET;
        else        state_q <= state_d;
    end

    always_comb begin
        set_ready = 1'b0;
        clr_ready = 1'b0;
        unique case (state_q)
            ARB_FAVOR_SET: begin
                set_ready = !dir_we;
                clr_ready = !dir_we && !set_valid;
            end
            ARB_FAVOR_CLR: begin
                set_ready = !dir_we && !clr_valid;
                clr_ready = !dir_we;
            end
            default: ;
        endcase
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        contest |-> $onehot({set_ready, clr_ready}));
    // R8
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (contest && set_ready) |=> (!contest || clr_ready));
    // R9
    direct_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |-> (!set_ready && !clr_ready));
    // R10
    lone_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_we && (set_valid != clr_valid)) |-> (set_ready || clr_ready));
endmodule

// File: rtl/swirq_regs.sv
module swirq_regs #(
    parameter int unsigned W  = 17,
    parameter int unsigned LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_we,
    input  logic [W-1:0]  dir_data,
    input  logic          set_fire,
    input  logic [W-1:0]  set_data,
    input  logic          clr_fire,
    input  logic [W-1:0]  clr_data,
    input  logic          pil_we,
    input  logic [LW-1:0] pil_data,
    output logic [W-1:0]  soft_q,
    output logic [LW-1:0] pil_q,
    output logic [W-1:0]  soft_nxt,
    output logic [LW-1:0] pil_nxt
);
    always_comb begin
        soft_nxt = soft_q;
        if (dir_we)        soft_nxt = dir_data;
        else if (set_fire) soft_nxt = soft_q | set_data;
        else if (clr_fire) soft_nxt = soft_q & ~clr_data;
        pil_nxt = pil_we ? pil_data : pil_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
            pil_q  <= '0;
        end else begin
            soft_q <= soft_nxt;
            pil_q  <= pil_nxt;
        end
    end

    // R3
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fire && !dir_we) |=> soft_q == ($past(soft_q) | $past(set_data)));
    // R4
    clr_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fire && !dir_we) |=> soft_q == ($past(soft_q) & ~$past(clr_data)));
    // R2
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> soft_q == $past(dir_data));
endmodule

// File: rtl/swirq_req_eval.sv
module swirq_req_eval #(
    parameter int unsigned W    = 17,
    parameter int unsigned LW   = 4,
    parameter int unsigned GATE = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  soft_nxt,
    input  logic [LW-1:0] pil_nxt,
    output logic [W-1:0]  req_q
);
    localparam logic [LW-1:0] GATE_V = GATE[LW-1:0];

    logic [W-1:0] req_d;
    logic         tick_open;

    assign tick_open = pil_nxt < GATE_V;

    assign req_d[0]   = soft_nxt[0]   && tick_open;
    assign req_d[W-1] = soft_nxt[W-1] && tick_open;

    for (genvar i = 1; i < W - 1; i++) begin : g_inner
        localparam logic [LW:0] IDX = i[LW:0];
        assign req_d[i] = soft_nxt[i] && ({1'b0, pil_nxt} < IDX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end
endmodule

// File: rtl/swirq_pend_ctrl.sv
module swirq_pend_ctrl
    import swirq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dir_we,
    input  logic [SWIRQ_W-1:0]     dir_data,
    input  logic                   set_valid,
    input  logic [SWIRQ_W-1:0]     set_data,
    output logic                   set_ready,
    input  logic                   clr_valid,
    input  logic [SWIRQ_W-1:0]     clr_data,
    output logic                   clr_ready,
    input  logic                   pil_we,
    input  logic [SWIRQ_LVL_W-1:0] pil_data,
    output logic [SWIRQ_W-1:0]     soft_rd,
    output logic [SWIRQ_LVL_W-1:0] pil_rd,
    output logic [SWIRQ_W-1:0]     int_req
);
    localparam int unsigned TOP = SWIRQ_W - 1;
    localparam logic [SWIRQ_LVL_W-1:0] GATE_V = SWIRQ_GATE[SWIRQ_LVL_W-1:0];

    logic [SWIRQ_W-1:0]     soft_nxt;
    logic [SWIRQ_LVL_W-1:0] pil_nxt;

    swirq_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_we    (dir_we),
        .set_valid (set_valid),
        .clr_valid (clr_valid),
        .set_ready (set_ready),
        .clr_ready (clr_ready)
    );

    swirq_regs #(.W(SWIRQ_W), .LW(SWIRQ_LVL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_we   (dir_we),
        .dir_data (dir_data),
        .set_fire (set_valid && set_ready),
        .set_data (set_data),
        .clr_fire (clr_valid && clr_ready),
        .clr_data (clr_data),
        .pil_we   (pil_we),
        .pil_data (pil_data),
        .soft_q   (soft_rd),
        .pil_q    (pil_rd),
        .soft_nxt (soft_nxt),
        .pil_nxt  (pil_nxt)
    );

    swirq_req_eval #(.W(SWIRQ_W), .LW(SWIRQ_LVL_W), .GATE(SWIRQ_GATE)) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_nxt (soft_nxt),
        .pil_nxt  (pil_nxt),
        .req_q    (int_req)
    );

    // R5
    tick_hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req[TOP] |-> (soft_rd[TOP] && pil_rd < GATE_V));
    // R5
    tick_lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req[0] |-> (soft_rd[0] && pil_rd < GATE_V));
    // R6
    req_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req & ~soft_rd) == '0);
    // R7
    level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pil_we |=> pil_rd == $past(pil_data));
endmodule

// File: tb/sim_swirq_pend_ctrl.sv
module sim_swirq_pend_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_we, set_valid, clr_valid, pil_we;
    logic [16:0] dir_data, set_data, clr_data;
    logic [3:0]  pil_data;
    logic        set_ready, clr_ready;
    logic [16:0] soft_rd, int_req;
    logic [3:0]  pil_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [16:0] m_soft;
    logic [3:0]  m_pil;

    always #(CLK_PERIOD/2) clk = ~clk;

    swirq_pend_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .dir_we(dir_we), .dir_data(dir_data),
        .set_valid(set_valid), .set_data(set_data), .set_ready(set_ready),
        .clr_valid(clr_valid), .clr_data(clr_data), .clr_ready(clr_ready),
        .pil_we(pil_we), .pil_data(pil_data),
        .soft_rd(soft_rd), .pil_rd(pil_rd), .int_req(int_req)
    );

    function automatic logic [16:0] model_req(logic [16:0] s, logic [3:0] p);
        logic [16:0] r;
        r[0]  = s[0]  && (p < 4'd14);
        r[16] = s[16] && (p < 4'd14);
        for (int i = 1; i < 16; i++) r[i] = s[i] && (i > int'(p));
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dir_we = 0; set_valid = 0; clr_valid = 0; pil_we = 0;
        dir_data = '0; set_data = '0; clr_data = '0; pil_data = '0;
    endtask

    // one write cycle: inputs driven at negedge, readies sampled before the edge
    task automatic cycle(output logic sr, output logic cr);
        #1;
        sr = set_ready;
        cr = clr_ready;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check_state(string req);
        chk({req, " flags"}, 32'(soft_rd), 32'(m_soft));
        chk({req, " level"}, 32'(pil_rd), 32'(m_pil));
        chk({req, " requests"}, 32'(int_req), 32'(model_req(m_soft, m_pil)));
    endtask

    task automatic t_reset();
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        m_soft = '0; m_pil = '0;
        // R1
        check_state("R1");
    endtask

    task automatic t_direct_and_inner();
        logic sr, cr;
        dir_we = 1; dir_data = 17'h1FFFF;
        cycle(sr, cr);
        m_soft = 17'h1FFFF;
        // R2, R6: level 0 posts every set bit
        check_state("R2");
        pil_we = 1; pil_data = 4'd7;
        cycle(sr, cr);
        m_pil = 4'd7;
        // R6, R7: only bits 8..15 plus both tick bits
        check_state("R6");
        chk("R6 explicit", 32'(int_req), 32'h1FF01);
    endtask

    task automatic t_tick_gate();
        logic sr, cr;
        pil_we = 1; pil_data = 4'd13;
        cycle(sr, cr);
        m_pil = 4'd13;
        // R5: level 13 keeps tick bits open
        chk("R5 level13", 32'(int_req), 32'h1C001);
        pil_we = 1; pil_data = 4'd14;
        cycle(sr, cr);
        m_pil = 4'd14;
        // R5: level 14 closes tick bits, leaves bit 15
        chk("R5 level14", 32'(int_req), 32'h08000);
        pil_we = 1; pil_data = 4'd15;
        cycle(sr, cr);
        m_pil = 4'd15;
        // R6: level 15 masks everything
        chk("R6 level15", 32'(int_req), 32'h0);
        check_state("R7");
    endtask

    task automatic t_set_clear();
        logic sr, cr;
        pil_we = 1; pil_data = 4'd2; dir_we = 1; dir_data = 17'h00010;
        cycle(sr, cr);
        m_pil = 4'd2; m_soft = 17'h00010;
        // R7: level and flags written together
        check_state("R7 joint");
        set_valid = 1; set_data = 17'h10005;
        cycle(sr, cr);
        m_soft = m_soft | 17'h10005;
        // R10
        chk("R10 lone set ready", 32'(sr), 32'd1);
        // R3
        check_state("R3");
        clr_valid = 1; clr_data = 17'h00014;
        cycle(sr, cr);
        m_soft = m_soft & ~17'h00014;
        chk("R10 lone clear ready", 32'(cr), 32'd1);
        // R4
        check_state("R4");
    endtask

    task automatic t_contest();
        logic sr, cr;
        set_valid = 1; set_data = 17'h00F00;
        clr_valid = 1; clr_data = 17'h10000;
        cycle(sr, cr);
        // R8: first contest after reset goes to set
        chk("R8 first set_ready", 32'(sr), 32'd1);
        chk("R8 first clr_ready", 32'(cr), 32'd0);
        m_soft = m_soft | 17'h00F00;
        check_state("R8 first");
        set_valid = 1; set_data = 17'h000F0;
        clr_valid = 1; clr_data = 17'h00300;
        cycle(sr, cr);
        // R8: second contest goes to clear
        chk("R8 second set_ready", 32'(sr), 32'd0);
        chk("R8 second clr_ready", 32'(cr), 32'd1);
        m_soft = m_soft & ~17'h00300;
        check_state("R8 second");
        set_valid = 1; set_data = 17'h00002;
        clr_valid = 1; clr_data = 17'h00001;
        cycle(sr, cr);
        chk("R8 third set_ready", 32'(sr), 32'd1);
        m_soft = m_soft | 17'h00002;
        check_state("R8 third");
    endtask

    task automatic t_direct_priority();
        logic sr, cr;
        dir_we = 1; dir_data = 17'h0A000;
        set_valid = 1; set_data = 17'h00FFF;
        clr_valid = 1; clr_data = 17'h0A000;
        cycle(sr, cr);
        // R9
        chk("R9 set_ready", 32'(sr), 32'd0);
        chk("R9 clr_ready", 32'(cr), 32'd0);
        m_soft = 17'h0A000;
        check_state("R9");
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG && !done) begin
                done = 1'b1;
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_direct_and_inner();
        t_tick_gate();
        t_set_clear();
        t_contest();
        t_direct_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule